// File: doc/BRIEF.md
# Glitch-free phase-select retimer

This block sits between a phase-select decoder and a multi-input phase multiplexer in a phase-switching programmable divider. It takes a set of equally spaced phase signals from the divider chain, where each phase lags the one before it by one input-clock cycle and is high for half of its period. It also takes a one-hot select from the decoder. For each phase it keeps one enable. The enables and retimed copies of the phases feed an AND-OR multiplexer, and that multiplexer drives the next divider stage.

An enable may only move from the current phase to the next lagging phase. It does so when the decoder asks for that phase and both phases are high. Under those conditions the switch can only stretch a high interval of the multiplexed output and can never cut one short. The decision is feedforward: each cell is set by the overlap of its own phase with the preceding one, and cleared by the overlap of its own phase with the following one. Nothing is fed back from the multiplexer output, so the decoder may change its select at any point in the phase cycle. The block is modelled synchronously at the input-clock rate. The phase copies go through as many register stages as the enable path, so a phase and its enable reach the multiplexer together.

Top module: `phase_retimer`

## Requirements
- R1: While `rst_n` is low, `sel_on` is 4'b0001 (only the 0-degree phase, bit 0, enabled), `phase_copy` is 0 and `mux_out` is 0.
- R2: After reset, `sel_on` has exactly one bit set in every cycle.
- R3: Enable bit i (bit 0 = 0 degrees, bit 1 = 90, bit 2 = 180, bit 3 = 270) turns on only after a cycle in which `phase_in[i-1]`, `phase_in[i]` and `sel_in[i]` were all high. Indices wrap modulo 4.
- R4: Enable bit i turns off only after a cycle in which `phase_in[i]`, `phase_in[i+1]` and `sel_in[i+1]` were all high. Indices wrap modulo 4.
- R5: When the turn-on and turn-off conditions of one enable bit hold in the same cycle, that bit is off in the next cycle.
- R6: A select that rises while its target phase is low does not move the enable. The enable moves at the clock edge that follows the first cycle in which the old and new phases are both high.
- R7: With the default single stage, `phase_copy` equals `phase_in` delayed by one clock, so it has the same latency as the path from select to enable.
- R8: `mux_out` is high exactly when some bit i has both `phase_copy[i]` and `sel_on[i]` high.
- R9: When the select moves one step lagging at any cycle offset and the phases follow their normal pattern, every high and every low interval of `mux_out` lasts at least 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_in | input | 4 | Sampled phases; bit i lags bit i-1 by one cycle |
| sel_in | input | 4 | One-hot phase request from the decoder |
| sel_on | output | 4 | Retimed one-hot enables, aligned with `phase_copy` |
| phase_copy | output | 4 | Phases delayed to match the enable path |
| mux_out | output | 1 | Multiplexed phase toward the next divider stage |

## Verification
The select is stepped one phase lagging at random cycle offsets against the free-running phase pattern. This shows that the enable always moves at the single overlap cycle and never at the request cycle, and that no output interval shrinks below two cycles. A directed case raises the select while the target phase is low, which separates a retimed enable from one that follows the decoder directly. A forced input pattern makes the turn-on and turn-off conditions of one cell coincide, which shows which of the two takes priority. Every cycle also compares the phase copies with the previous inputs and the output with the enabled phase.

// File: rtl/rtm_pkg.sv
package rtm_pkg;

   // Wrap a possibly negative phase index into 0 .. n-1.
   function automatic int wrap_idx(input int i, input int n);
      return ((i % n) + n) % n;
   endfunction

   // One-hot word with only bit k set.
   function automatic logic [31:0] onehot_bit(input int k);
      return 32'd1 << k;
   endfunction

endpackage

// File: rtl/rtm_cell.sv
module rtm_cell #(
   parameter bit RST_ON = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_c,
   input  logic clr_c,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST_ON;
      else if (clr_c) q <= 1'b0;
      else if (set_c) q <= 1'b1;
   end

   // R3: the enable rises only after its entry window was seen
   assert_set_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q) |-> $past(set_c));

   // R4: the enable falls only after its exit window was seen
   assert_clr_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(q) |-> $past(clr_c));

   // R5: a coincident entry and exit leaves the enable off
   assert_clear_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(set_c && clr_c)) |-> !q);

endmodule

// File: rtl/rtm_delay.sv
module rtm_delay #(
   parameter int             W       = 4,
   parameter int             DEPTH   = 1,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (DEPTH < 0) begin : g_bad_depth
         $error("rtm_delay: DEPTH must not be negative");
      end

      if (DEPTH == 0) begin : g_wire
         assign dout = din;
      end else begin : g_pipe
         logic [W-1:0] stg [DEPTH];
         for (genvar k = 0; k < DEPTH; k++) begin : g_stage
            logic [W-1:0] stg_in;
            if (k == 0) begin : g_first
               assign stg_in = din;
            end else begin : g_next
               assign stg_in = stg[k-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[k] <= RST_VAL;
               else        stg[k] <= stg_in;
            end

            // R7: every stage adds exactly one cycle of latency
            assert_stage_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
               $past(rst_n) |-> (stg[k] == $past(stg_in)));
         end
         assign dout = stg[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/rtm_mux.sv
module rtm_mux #(
   parameter int N = 4
) (
   input  logic [N-1:0] ph,
   input  logic [N-1:0] en,
   output logic         out
);

   logic [N-1:0] gated;

   generate
      for (genvar i = 0; i < N; i++) begin : g_gate
         assign gated[i] = ph[i] & en[i];
      end
   endgenerate

   assign out = |gated;

endmodule

// File: rtl/phase_retimer.sv
module phase_retimer #(
   parameter int NUM_PH      = 4,
   parameter int CTRL_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_PH-1:0] phase_in,
   input  logic [NUM_PH-1:0] sel_in,
   output logic [NUM_PH-1:0] sel_on,
   output logic [NUM_PH-1:0] phase_copy,
   output logic              mux_out
);
   import rtm_pkg::*;

   localparam int                EXTRA_EN  = CTRL_STAGES - 1;
   localparam logic [NUM_PH-1:0] RST_SEL   = NUM_PH'(1);

   generate
      if (NUM_PH < 4 || (NUM_PH % 2) != 0) begin : g_bad_ph
         $error("phase_retimer: NUM_PH must be even and at least 4");
      end
      if (CTRL_STAGES < 1) begin : g_bad_stages
         $error("phase_retimer: CTRL_STAGES must be at least 1");
      end
   endgenerate

   logic [NUM_PH-1:0] set_v;
   logic [NUM_PH-1:0] clr_v;
   logic [NUM_PH-1:0] lat_q;

   // One latch cell per phase: entry window with the leading neighbour,
   // exit window with the lagging neighbour.
   generate
      for (genvar i = 0; i < NUM_PH; i++) begin : g_cell
         localparam int PREV = wrap_idx(i - 1, NUM_PH);
         localparam int NEXT = wrap_idx(i + 1, NUM_PH);

         assign set_v[i] = phase_in[PREV] & phase_in[i] & sel_in[i];
         assign clr_v[i] = phase_in[i] & phase_in[NEXT] & sel_in[NEXT];

         rtm_cell #(
            .RST_ON (i == 0)
         ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_c (set_v[i]),
            .clr_c (clr_v[i]),
            .q     (lat_q[i])
         );
      end
   endgenerate

   // Extra control-path stages beyond the latch (none by default).
   rtm_delay #(
      .W       (NUM_PH),
      .DEPTH   (EXTRA_EN),
      .RST_VAL (RST_SEL)
   ) u_en_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (lat_q),
      .dout  (sel_on)
   );

   // Phase copies see the full control-path latency.
   rtm_delay #(
      .W       (NUM_PH),
      .DEPTH   (CTRL_STAGES),
      .RST_VAL ('0)
   ) u_ph_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (phase_in),
      .dout  (phase_copy)
   );

   rtm_mux #(
      .N (NUM_PH)
   ) u_mux (
      .ph  (phase_copy),
      .en  (sel_on),
      .out (mux_out)
   );

   // R2: the multiplexer always has exactly one source
   assert_single_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(sel_on));

   // R8: output high implies an enabled phase copy is high
   assert_output_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mux_out |-> ((phase_copy & sel_on) != '0));

endmodule

// File: tb/phase_retimer_tb.sv
module phase_retimer_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] ph_in;
   logic [3:0] sel;
   logic [3:0] sel_on;
   logic [3:0] phase_copy;
   logic       mux_out;

   int   total = 0;
   int   bad   = 0;
   bit   done  = 0;
   int   q     = 0;
   int   cur   = 0;
   logic [3:0] pre_ph, pre_sel;
   bit   track = 0;
   int   run_len;
   logic last_out;

   always #4 clk = ~clk;

   phase_retimer #(.NUM_PH(4), .CTRL_STAGES(1)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase_in   (ph_in),
      .sel_in     (sel),
      .sel_on     (sel_on),
      .phase_copy (phase_copy),
      .mux_out    (mux_out)
   );

   function automatic logic [3:0] oh(input int i);
      return 4'b0001 << (((i % 4) + 4) % 4);
   endfunction

   // Phase i is high when the step count equals i or i+1 (mod 4).
   function automatic logic [3:0] pat(input int s);
      return oh(s) | oh(s + 3);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic adv();
      q = (q + 1) % 4;
      ph_in = pat(q);
   endtask

   task automatic tick();
      pre_ph  = ph_in;
      pre_sel = sel;
      @(posedge clk);
      #1;
      chk(phase_copy == pre_ph, "R7 copy", phase_copy, pre_ph);
      chk(mux_out == |(phase_copy & sel_on), "R8 mux", mux_out, |(phase_copy & sel_on));
      chk($onehot(sel_on), "R2 onehot", sel_on, oh(cur));
      if (track) begin
         if (mux_out == last_out) run_len++;
         else begin
            chk(run_len >= 2, "R9 interval", run_len, 2);
            run_len = 1;
         end
         last_out = mux_out;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      ph_in = 4'b0000;
      sel   = 4'b0001;
      repeat (3) @(posedge clk);
      #1;
      chk(sel_on == 4'b0001, "R1 enable", sel_on, 4'b0001);
      chk(phase_copy == 4'b0000, "R1 copy", phase_copy, 0);
      chk(mux_out == 1'b0, "R1 out", mux_out, 0);
      rst_n = 1'b1;
      q     = 0;
      ph_in = pat(0);
      cur   = 0;
   endtask

   task automatic t_free_run();
      for (int k = 0; k < 8; k++) begin
         tick();
         chk(sel_on == oh(cur), "R3 hold", sel_on, oh(cur));
         adv();
      end
   endtask

   // R3 R4 R9: single lagging steps at random offsets
   task automatic t_random_steps();
      track    = 1;
      run_len  = 2;
      last_out = mux_out;
      for (int s = 0; s < 24; s++) begin
         int wait_n;
         int nxt;
         wait_n = $urandom_range(0, 3);
         for (int w = 0; w < wait_n; w++) begin
            tick();
            adv();
         end
         nxt = (cur + 1) % 4;
         sel = oh(nxt);
         for (int w = 0; w < 6; w++) begin
            int exp_i;
            tick();
            exp_i = cur;
            if (pre_sel == oh(nxt) && pre_ph[cur] && pre_ph[nxt]) exp_i = nxt;
            chk(sel_on == oh(exp_i), "R3/R4 step", sel_on, oh(exp_i));
            cur = exp_i;
            adv();
         end
         chk(cur == nxt, "R3 moved", cur, nxt);
      end
      track = 0;
   endtask

   // R6: select rises while target phase is still low
   task automatic t_late_select();
      int nxt;
      nxt = (cur + 1) % 4;
      while (q != (nxt + 2) % 4) begin
         tick();
         adv();
      end
      sel = oh(nxt);
      tick();
      chk(sel_on == oh(cur), "R6 wait1", sel_on, oh(cur));
      adv();
      tick();
      chk(sel_on == oh(cur), "R6 wait2", sel_on, oh(cur));
      adv();
      tick();
      chk(sel_on == oh(nxt), "R6 switch", sel_on, oh(nxt));
      cur = nxt;
      adv();
   endtask

   // R5: entry and exit of one cell coincide
   task automatic t_clear_wins();
      int c1;
      int c2;
      c1 = (cur + 1) % 4;
      c2 = (cur + 2) % 4;
      ph_in = oh(cur) | oh(c1) | oh(c2);
      sel   = oh(c1) | oh(c2);
      tick();
      chk(sel_on == oh(c2), "R5 clear wins", sel_on, oh(c2));
      cur   = c2;
      sel   = oh(cur);
      q     = 0;
      ph_in = pat(0);
      for (int k = 0; k < 4; k++) begin
         tick();
         chk(sel_on == oh(cur), "R5 settle", sel_on, oh(cur));
         adv();
      end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      t_reset();
      t_free_run();
      t_random_steps();
      t_late_select();
      t_late_select();
      t_clear_wins();
      t_random_steps();
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

endmodule